// File: doc/BRIEF.md
# Copy Authorization Gate

This block rules on each request to commit the 8-byte scratchpad into memory. Each request carries a target address and a status byte. The block checks them against the address and status registers held outside it, the per-page protection bytes and a single copy-lock byte. One clock after the request strobe it answers with either a grant or a deny. A grant also produces a one-cycle write-enable toward the memory array, the committed base address, and a pulse that sets the copied flag in the status register. A deny produces no write and no flag pulse.

The target space has three regions:

- main memory at 0000h–007Fh, as four pages of 32 bytes;
- a register row at 0080h–0087h;
- a user row at 0088h–008Fh.

Every other address is outside the map. A write-protected main page (protection byte 55h) may still be copied, so that its contents can be refreshed. Once the copy-lock byte holds 55h or AAh, the block refuses three kinds of copy: refreshes of write-protected pages, copies to the register row and copies to the user row.

The controller has three states. **IDLE** waits for a request. **GRANT** and **DENY** each last one cycle. A request seen in any state moves the controller to GRANT when every rule passes and to DENY otherwise. A cycle with no request returns it to IDLE.

Top module: `copy_auth_gate`

## Requirements
- R1: A cycle with `req` high is followed, in the next cycle, by exactly one of `grant` or `deny` high for one cycle. When the previous cycle had no request, both are low. Back-to-back requests each receive their own verdict.
- R2: The request is denied when `req_addr` differs from `stored_ta`, or when `req_es` differs from `stored_es`.
- R3: A full image is required. The low three bits of `stored_ta` must be 0, the ending offset `stored_es[2:0]` must be 7, and the partial flag `stored_es[5]` must be 0. Otherwise the request is denied. The copied flag `stored_es[7]` has no effect on the verdict.
- R4: With the copy-lock byte at any value other than 55h or AAh, a main page whose protection byte is 55h is granted, so a refresh is allowed.
- R5: With the copy-lock byte at 55h or AAh, a copy to a main page whose protection byte is 55h is denied. Main pages with any other protection byte, including AAh, are still granted. Page n takes its protection byte from `page_prot[8n+7:8n]`, and n is address bits [6:5].
- R6: With the copy-lock byte at 55h or AAh, every copy to the register row (0080h–0087h) or to the user row (0088h–008Fh) is denied. With any other copy-lock value, these copies are granted.
- R7: A target at 0090h or above is always denied.
- R8: A grant drives `commit_we` and `set_copied` high for exactly that cycle, with `commit_addr` equal to the requested target. A deny leaves both low.
- R9: While `rst_n` is low, `grant`, `deny`, `commit_we` and `set_copied` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Copy request strobe |
| req_addr | input | 16 | Target address carried by the request |
| req_es | input | 8 | Status byte carried by the request |
| stored_ta | input | 16 | Stored target address register |
| stored_es | input | 8 | Stored status: bit 7 copied, bit 5 partial, bits 2:0 ending offset |
| page_prot | input | 32 | Protection bytes of the four main pages, page n at bits 8n+7:8n |
| copy_lock | input | 8 | Copy-lock byte; armed at 55h or AAh |
| grant | output | 1 | Request accepted, one cycle |
| deny | output | 1 | Request refused, one cycle |
| commit_we | output | 1 | One-cycle write-enable toward the array |
| commit_addr | output | 16 | Target base address of the commit |
| set_copied | output | 1 | Pulse that sets the copied flag |

## Verification
The assertions take for granted that the stored registers, protection bytes and copy-lock byte are steady for the cycle in which a request is sampled. Each `$past` check relies on this, because it relates a verdict to the inputs one edge earlier. The stimulus drives every input at the falling edge and holds it across the rising edge that samples it. It changes the protection and lock bytes only between requests or together with a new request. Requests arrive as isolated strobes and also as back-to-back pairs.

// File: rtl/copy_auth_pkg.sv
package copy_auth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } gate_state_t;

    typedef enum logic [1:0] {
        RGN_MAIN = 2'd0,
        RGN_REG  = 2'd1,
        RGN_USER = 2'd2,
        RGN_NONE = 2'd3
    } region_t;

    localparam logic [7:0] LOCK_CODE  = 8'h55;
    localparam logic [7:0] EPROM_CODE = 8'hAA;
    localparam int         PF_BIT     = 5;

    function automatic logic lock_armed(input logic [7:0] b);
        return (b == LOCK_CODE) || (b == EPROM_CODE);
    endfunction

endpackage

// File: rtl/cag_region_decode.sv
module cag_region_decode
    import copy_auth_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 32,
    parameter int ROW_BYTES  = 8,
    parameter int PG_W       = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [PG_W-1:0]   page_idx
);
    localparam int PB_SH = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] MAIN_TOP  = ADDR_W'(NUM_PAGES * PAGE_BYTES);
    localparam logic [ADDR_W-1:0] USER_BASE = ADDR_W'(NUM_PAGES * PAGE_BYTES + ROW_BYTES);
    localparam logic [ADDR_W-1:0] MAP_END   = ADDR_W'(NUM_PAGES * PAGE_BYTES + 2 * ROW_BYTES);

    assign page_idx = addr[PB_SH +: PG_W];

    always_comb begin
        if (addr < MAIN_TOP)       region = RGN_MAIN;
        else if (addr < USER_BASE) region = RGN_REG;
        else if (addr < MAP_END)   region = RGN_USER;
        else                       region = RGN_NONE;
    end
endmodule

// File: rtl/cag_page_lookup.sv
module cag_page_lookup #(
    parameter int NUM_PAGES = 4,
    parameter int PG_W      = 2
) (
    input  logic [NUM_PAGES*8-1:0] page_prot,
    input  logic [PG_W-1:0]        page_idx,
    output logic [7:0]             page_byte
);
    logic [7:0] prot_arr [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_unpack
        assign prot_arr[g] = page_prot[8*g +: 8];
    end

    always_comb begin
        page_byte = 8'h00;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (PG_W'(i) == page_idx) page_byte = prot_arr[i];
        end
    end
endmodule

// File: rtl/cag_verdict.sv
module cag_verdict
    import copy_auth_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_es,
    input  logic [ADDR_W-1:0] stored_ta,
    input  logic [7:0]        stored_es,
    input  region_t           region,
    input  logic [7:0]        page_byte,
    input  logic [7:0]        copy_lock,
    output logic              allow
);
    logic regs_match;
    logic image_full;
    logic region_ok;
    logic armed;

    assign armed      = lock_armed(copy_lock);
    assign regs_match = (req_addr == stored_ta) && (req_es == stored_es);
    assign image_full = (stored_ta[OFF_W-1:0] == '0)
                     && (stored_es[OFF_W-1:0] == '1)
                     && !stored_es[PF_BIT];

    always_comb begin
        unique case (region)
            RGN_MAIN: region_ok = !(armed && (page_byte == LOCK_CODE));
            RGN_REG,
            RGN_USER: region_ok = !armed;
            default:  region_ok = 1'b0;
        endcase
    end

    assign allow = regs_match && image_full && region_ok;
endmodule

// File: rtl/copy_auth_gate.sv
module copy_auth_gate
    import copy_auth_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 32,
    parameter int ROW_BYTES  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [7:0]             req_es,
    input  logic [ADDR_W-1:0]      stored_ta,
    input  logic [7:0]             stored_es,
    input  logic [NUM_PAGES*8-1:0] page_prot,
    input  logic [7:0]             copy_lock,
    output logic                   grant,
    output logic                   deny,
    output logic                   commit_we,
    output logic [ADDR_W-1:0]      commit_addr,
    output logic                   set_copied
);
    localparam int PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int OFF_W = $clog2(ROW_BYTES);
    localparam logic [ADDR_W-1:0] MAIN_TOP = ADDR_W'(NUM_PAGES * PAGE_BYTES);
    localparam logic [ADDR_W-1:0] MAP_END  = ADDR_W'(NUM_PAGES * PAGE_BYTES + 2 * ROW_BYTES);

    region_t           region;
    logic [PG_W-1:0]   page_idx;
    logic [7:0]        page_byte;
    logic              allow;
    gate_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    cag_region_decode #(
        .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
        .ROW_BYTES(ROW_BYTES), .PG_W(PG_W)
    ) u_decode (
        .addr(req_addr), .region(region), .page_idx(page_idx)
    );

    cag_page_lookup #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) u_lookup (
        .page_prot(page_prot), .page_idx(page_idx), .page_byte(page_byte)
    );

    cag_verdict #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_verdict (
        .req_addr(req_addr), .req_es(req_es), .stored_ta(stored_ta),
        .stored_es(stored_es), .region(region), .page_byte(page_byte),
        .copy_lock(copy_lock), .allow(allow)
    );

    // Next-state logic: a request always yields a verdict next cycle.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE,
            ST_GRANT,
            ST_DENY: begin
                if (req) state_d = allow ? ST_GRANT : ST_DENY;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req) addr_q <= req_addr;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        grant      = 1'b0;
        deny       = 1'b0;
        commit_we  = 1'b0;
        set_copied = 1'b0;
        unique case (state_q)
            ST_GRANT: begin
                grant      = 1'b1;
                commit_we  = 1'b1;
                set_copied = 1'b1;
            end
            ST_DENY:  deny = 1'b1;
            default:  ;
        endcase
    end
    assign commit_addr = addr_q;

    logic cp_armed;
    assign cp_armed = lock_armed(copy_lock);

    assert_single_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));
    assert_req_gets_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (grant || deny));
    assert_verdict_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || deny) |-> $past(req));
    assert_grant_regs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past((req_addr == stored_ta) && (req_es == stored_es)));
    assert_grant_full_image_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past((stored_es[OFF_W-1:0] == '1) && !stored_es[PF_BIT]
                        && (stored_ta[OFF_W-1:0] == '0)));
    assert_lock_blocks_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !$past(cp_armed && (req_addr < MAIN_TOP) && (page_byte == LOCK_CODE)));
    assert_lock_blocks_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !$past(cp_armed && (req_addr >= MAIN_TOP)));
    assert_outside_map_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(req_addr < MAP_END));
    assert_commit_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |-> (commit_addr == $past(req_addr)));
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(!rst_n) |-> !(grant || deny || commit_we || set_copied));
endmodule

// File: tb/test_copy_auth_gate.sv
`timescale 1ns/1ps
module test_copy_auth_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_es = '0;
    logic [15:0] stored_ta = '0;
    logic [7:0]  stored_es = '0;
    logic [31:0] page_prot = '0;
    logic [7:0]  copy_lock = '0;
    logic        grant, deny, commit_we, set_copied;
    logic [15:0] commit_addr;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    copy_auth_gate i_copy_auth_gate (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_es(req_es),
        .stored_ta(stored_ta), .stored_es(stored_es), .page_prot(page_prot),
        .copy_lock(copy_lock), .grant(grant), .deny(deny), .commit_we(commit_we),
        .commit_addr(commit_addr), .set_copied(set_copied)
    );

    // Behavioural reference: verdict for the inputs seen at the coming edge.
    function automatic void model(output logic eg, output logic ed);
        int ta, es, pg, pb;
        bit armed, ok;
        eg = 1'b0; ed = 1'b0;
        if (!rst_n || !req) return;
        ta = int'(stored_ta); es = int'(stored_es);
        armed = (copy_lock == 8'h55) || (copy_lock == 8'hAA);
        ok = (req_addr == stored_ta) && (req_es == stored_es);
        if (ta % 8 != 0 || es % 8 != 7 || (es / 32) % 2 == 1) ok = 0;
        if (ta < 128) begin
            pg = ta / 32;
            pb = int'(page_prot[pg*8 +: 8]);
            if (armed && pb == 'h55) ok = 0;
        end else if (ta < 144) begin
            if (armed) ok = 0;
        end else ok = 0;
        eg = ok; ed = !ok;
    endfunction

    task automatic step(input string tag);
        logic eg, ed;
        logic [15:0] ea;
        model(eg, ed);
        ea = req_addr;
        @(posedge clk);
        @(negedge clk);
        compared++;
        if (grant !== eg || deny !== ed || commit_we !== eg || set_copied !== eg
            || (eg && commit_addr !== ea)) begin
            mismatched++;
            $display("FAIL %s: g/d/we/set=%b%b%b%b addr=%h expected %b%b%b%b addr=%h",
                     tag, grant, deny, commit_we, set_copied, commit_addr,
                     eg, ed, eg, eg, ea);
        end
    endtask

    // Present one matching request, then one idle cycle.
    task automatic copy(input logic [15:0] ta, input logic [7:0] es,
                        input logic [7:0] lock, input string tag);
        stored_ta = ta; stored_es = es; req_addr = ta; req_es = es;
        copy_lock = lock; req = 1'b1;
        step(tag);
        req = 1'b0;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL R1: watchdog expired, actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R9: reset quiet even with a request present
        req = 1'b1; stored_es = 8'h07; req_es = 8'h07;
        step("R9"); step("R9");
        req = 1'b0;
        rst_n = 1'b1;
        step("R1 idle");
        step("R1 idle");

        // R8: plain grant on page 0, copied flag already set (R3 ignores bit 7)
        page_prot = 32'h00AA_5500;   // page1=55h, page2=AAh
        copy(16'h0000, 8'h07, 8'h00, "R8");
        copy(16'h0018, 8'h87, 8'h00, "R3 copied flag");
        // R4: refresh of write-protected page allowed when lock disarmed
        copy(16'h0020, 8'h07, 8'h00, "R4");
        copy(16'h0028, 8'h07, 8'h12, "R4");
        // R5: lock armed
        copy(16'h0020, 8'h07, 8'h55, "R5 protected page");
        copy(16'h0038, 8'h07, 8'hAA, "R5 protected page");
        copy(16'h0040, 8'h07, 8'hAA, "R5 eprom page");
        copy(16'h0060, 8'h07, 8'h55, "R5 open page");
        // R6: register and user rows
        copy(16'h0080, 8'h07, 8'h00, "R6 reg open");
        copy(16'h0080, 8'h07, 8'hAA, "R6 reg locked");
        copy(16'h0088, 8'h07, 8'h55, "R6 user locked");
        copy(16'h0088, 8'h07, 8'h54, "R6 user open");
        // R7: outside map
        copy(16'h0090, 8'h07, 8'h00, "R7");
        copy(16'hFF00, 8'h07, 8'h00, "R7");
        // R3: incomplete images
        copy(16'h0000, 8'h27, 8'h00, "R3 partial");
        copy(16'h0000, 8'h05, 8'h00, "R3 short");
        copy(16'h0003, 8'h07, 8'h00, "R3 offset");

        // R2: request differs from stored registers
        stored_ta = 16'h0008; stored_es = 8'h07; copy_lock = 8'h00;
        req_addr = 16'h0010; req_es = 8'h07; req = 1'b1;
        step("R2 addr");
        req_addr = 16'h0008; req_es = 8'h27;
        step("R2 es");
        req_es = 8'h07;
        step("R2 match");
        req = 1'b0;
        step("R2");

        // R1: back-to-back requests with alternating verdicts
        req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            req_addr = (k % 2 == 0) ? 16'h0048 : 16'h0090;
            stored_ta = req_addr;
            step("R1 back-to-back");
        end
        req = 1'b0;
        step("R1 idle");
        step("R1 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule